// File: doc/BRIEF.md
# Second-Order Noise-Shaping Bitstream Modulator

The block turns a stream of 16-bit two's complement samples into a single-bit stream for a one-bit DAC. It runs at the oversampled rate. Each cycle in which the clock enable is high takes in one input word and produces one output bit, so the bit rate equals the word rate. With an oversampling ratio of 32, the output carries an 8 kHz-rate signal. A second-order error-feedback loop pushes the quantization error out of the band below about 4 kHz.

The input can be driven by an interpolation filter, or by a held host word when that filter is bypassed. The block treats both the same way. The loop uses two saturating integrators. Each integrator adds the difference between its input and the fed-back level. The fed-back level is the positive or negative full-scale code, chosen by the previous output bit. Saturation, rather than wrap-around, keeps the loop recoverable when the input stays at or near full scale.

Top module: `sdm_bitstream_mod`

## Requirements
- R1: While `rst_n` is low, `bit_o` is 0 without waiting for a clock edge, and both integrators are cleared. After `rst_n` rises, the block stays idle until two clock edges have synchronised the release.
- R2: A cycle with `ce` low changes neither the integrators nor `bit_o`, whatever `sample_i` carries. The sequence resumes exactly where it stopped.
- R3: The feedback level is f = +32767 when `bit_o` is 1 and f = -32768 when it is 0. On a rising edge with `ce` high, the first integrator becomes a1' = clip(a1 + x - f), where x is `sample_i` read as signed. The second becomes a2' = clip(a2 + a1' - f). `bit_o` becomes 1 exactly when a2' >= 0.
- R4: clip limits each integrator to the range -(2^(IW-1)-1) to +(2^(IW-1)-1), with IW = 20 by default. Integrators never wrap. A constant input of 0x7FFF gives at least 500 ones in 512 enabled samples, and 0x8000 gives at most 12.
- R5: A zero input gives between 510 and 514 ones in 1024 enabled samples after reset.
- R6: For a constant input x, the mean feedback level over 2048 enabled samples lies within 300 LSB of x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce | input | 1 | Sample enable at the oversampled rate |
| sample_i | input | 16 | Two's complement input word |
| bit_o | output | 1 | Registered one-bit output |

## Verification
The bench holds the input at both full-scale codes for hundreds of samples. An integrator that wraps instead of clipping would flip sign there and make the bitstream collapse or oscillate, breaking the density bounds and the exact bit sequence. Long gaps with `ce` low and a changing input catch a design that lets stray words leak into the integrators. Those gaps also catch a design that advances the output outside enabled cycles. A reset asserted mid-stream is checked immediately at the output, which exposes a synchronous-only clear. Zero and mid-scale DC inputs check feedback polarity and the loop's mean: a swapped feedback sign or a wrong full-scale constant drives the ones density away from the input's value.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int SDM_DATA_W  = 16;
  localparam int SDM_INTEG_W = 20;

  // largest magnitude an integrator of width w may hold (symmetric clip)
  function automatic int unsigned clip_limit(input int w);
    return (32'd1 << (w - 1)) - 32'd1;
  endfunction
endpackage

// File: rtl/sdm_reset_sync.sv
module sdm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sdm_sat_integrator.sv
module sdm_sat_integrator #(
  parameter int IW = sdm_pkg::SDM_INTEG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [IW-1:0] add_i,
  input  logic signed [IW-1:0] sub_i,
  output logic signed [IW-1:0] acc_d_o,
  output logic signed [IW-1:0] acc_q_o
);
  localparam int SW = IW + 2;
  localparam logic signed [SW-1:0] LIM_POS = SW'(sdm_pkg::clip_limit(IW));
  localparam logic signed [SW-1:0] LIM_NEG = -LIM_POS;

  logic signed [SW-1:0] sum_w;
  logic signed [IW-1:0] acc_q;
  logic signed [IW-1:0] acc_sat;

  always_comb begin
    sum_w = {{2{acc_q[IW-1]}}, acc_q}
          + {{2{add_i[IW-1]}}, add_i}
          - {{2{sub_i[IW-1]}}, sub_i};
    if (sum_w > LIM_POS)      acc_sat = LIM_POS[IW-1:0];
    else if (sum_w < LIM_NEG) acc_sat = LIM_NEG[IW-1:0];
    else                      acc_sat = sum_w[IW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_sat;
  end

  assign acc_d_o = acc_sat;
  assign acc_q_o = acc_q;

  // R2
  integ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q_o));

  // R4
  no_wrap_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !acc_q_o[IW-1] && (add_i >= sub_i)) |=> !acc_q_o[IW-1]);

  // R4
  no_wrap_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && acc_q_o[IW-1] && (add_i <= sub_i)) |=> acc_q_o[IW-1]);
endmodule

// File: rtl/sdm_quantizer.sv
module sdm_quantizer #(
  parameter int DW = sdm_pkg::SDM_DATA_W,
  parameter int IW = sdm_pkg::SDM_INTEG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 level_neg_i,
  output logic                 bit_o,
  output logic signed [IW-1:0] fb_o
);
  localparam logic signed [IW-1:0] FB_HI = IW'((1 << (DW - 1)) - 1);
  localparam logic signed [IW-1:0] FB_LO = -IW'(1 << (DW - 1));

  logic bit_q;
  logic bit_d;

  always_comb begin
    bit_d = en ? !level_neg_i : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_d;
  end

  assign bit_o = bit_q;
  assign fb_o  = bit_q ? FB_HI : FB_LO;
endmodule

// File: rtl/sdm_bitstream_mod.sv
module sdm_bitstream_mod #(
  parameter int DW = sdm_pkg::SDM_DATA_W,
  parameter int IW = sdm_pkg::SDM_INTEG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [DW-1:0] sample_i,
  output logic          bit_o
);
  logic                 rst_core_n;
  logic signed [IW-1:0] x_ext;
  logic signed [IW-1:0] fb_w;
  logic signed [IW-1:0] i1_d;
  logic signed [IW-1:0] i1_q;
  logic signed [IW-1:0] i2_d;
  logic signed [IW-1:0] i2_q;
  logic                 bit_w;

  sdm_reset_sync #(.STAGES(2)) rsync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  always_comb begin
    x_ext = {{(IW-DW){sample_i[DW-1]}}, sample_i};
  end

  sdm_sat_integrator #(.IW(IW)) integ1_i (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .en      (ce),
    .add_i   (x_ext),
    .sub_i   (fb_w),
    .acc_d_o (i1_d),
    .acc_q_o (i1_q)
  );

  sdm_sat_integrator #(.IW(IW)) integ2_i (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .en      (ce),
    .add_i   (i1_d),
    .sub_i   (fb_w),
    .acc_d_o (i2_d),
    .acc_q_o (i2_q)
  );

  sdm_quantizer #(.DW(DW), .IW(IW)) quant_i (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .en          (ce),
    .level_neg_i (i2_d[IW-1]),
    .bit_o       (bit_w),
    .fb_o        (fb_w)
  );

  assign bit_o = bit_w;

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !ce |=> $stable(bit_o));

  // R3
  bit_sign_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ce |=> (bit_o == !i2_q[IW-1]));
endmodule

// File: tb/sdm_bitstream_mod_tb.sv
module sdm_bitstream_mod_tb_top;
  localparam int LIM = (1 << 19) - 1;

  logic        clk;
  logic        rst_n;
  logic        ce;
  logic [15:0] sample_i;
  logic        bit_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  longint m_i1, m_i2;
  bit     m_bit;
  bit     last_en;
  int     ones, nsamp;

  sdm_bitstream_mod dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sample_i(sample_i), .bit_o(bit_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic longint clip(input longint v);
    if (v > LIM)  return LIM;
    if (v < -LIM) return -LIM;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: compare output, then drive next inputs and advance the model
  task automatic cyc(input int x, input bit en);
    longint fb, n1, n2;
    @(negedge clk);
    check("R3", bit_o, m_bit);
    if (last_en) begin
      ones += bit_o;
      nsamp++;
    end
    sample_i = x[15:0];
    ce = en;
    last_en = en;
    if (en) begin
      fb = m_bit ? 32767 : -32768;
      n1 = clip(m_i1 + x - fb);
      n2 = clip(m_i2 + n1 - fb);
      m_i1 = n1;
      m_i2 = n2;
      m_bit = (n2 >= 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ce = 1'b0;
    last_en = 1'b0;
    m_i1 = 0; m_i2 = 0; m_bit = 0;
    #1;
    check("R1 async clear", bit_o, 0);
    repeat (3) @(negedge clk);
    check("R1 held in reset", bit_o, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(i * 1000, 1'b0);
  endtask

  task automatic run_dc(input int x, input int n);
    for (int i = 0; i < n; i++) cyc(x, 1'b1);
    cyc(x, 1'b0);
  endtask

  task automatic start_count();
    ones = 0;
    nsamp = 0;
  endtask

  task automatic check_mean(input string req, input int x);
    longint err;
    err = longint'(ones) * 65535 - longint'(nsamp) * 32768 - longint'(nsamp) * x;
    if (err < 0) err = -err;
    checks++;
    if (err > 300 * longint'(nsamp)) begin
      errors++;
      $display("FAIL %s mean error*N actual=%0d expected<=%0d", req, err, 300 * nsamp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit held;
    rst_n = 1'b1; ce = 1'b0; sample_i = '0;
    m_i1 = 0; m_i2 = 0; m_bit = 0; last_en = 0;
    ones = 0; nsamp = 0;
    #1 rst_n = 1'b0;
    #1;
    check("R1 reset state", bit_o, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(0, 1'b0);

    // R5: zero input density
    start_count();
    run_dc(0, 1024);
    checks++;
    if (ones < 510 || ones > 514) begin
      errors++;
      $display("FAIL R5 ones actual=%0d expected=510..514", ones);
    end

    // R2: enable low with changing input leaves state untouched
    held = bit_o;
    for (int i = 0; i < 20; i++) cyc(i * 3001 - 30000, 1'b0);
    check("R2 output held while idle", bit_o, held);
    for (int i = 0; i < 64; i++) cyc(5000, 1'b1);

    // R3: triangle input with enable every third cycle
    for (int i = 0; i < 768; i++) begin
      int ph, tri_v;
      ph = (i / 3) % 64;
      tri_v = (ph < 32) ? (ph * 1250 - 20000) : ((63 - ph) * 1250 - 20000);
      cyc(tri_v, (i % 3) == 0);
    end

    // R6: DC means
    do_reset();
    start_count();
    run_dc(12000, 2048);
    check_mean("R6 dc +12000", 12000);
    do_reset();
    start_count();
    run_dc(-20000, 2048);
    check_mean("R6 dc -20000", -20000);

    // R4: full scale both ways, no wrap
    do_reset();
    start_count();
    run_dc(32767, 512);
    checks++;
    if (ones < 500) begin
      errors++;
      $display("FAIL R4 +full ones actual=%0d expected>=500", ones);
    end
    start_count();
    run_dc(-32768, 512);
    start_count();
    run_dc(-32768, 512);
    checks++;
    if (ones > 12) begin
      errors++;
      $display("FAIL R4 -full ones actual=%0d expected<=12", ones);
    end

    // R1: reset mid-stream, then recovery tracked by the model
    do_reset();
    run_dc(-7000, 256);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule